// File: doc/BRIEF.md
# Link bring-up reset sequencer

This block takes a serial-link controller and its PHY from a held-reset condition to the point where link training runs. It then watches the link-up status until the link is reported up or a time budget runs out. A single start pulse runs the whole order of steps. The steps are:

- hold the PHY in test power-down while training is forced on and the endpoint is held in reset;
- release the endpoint, drop training while static PHY settings are applied;
- turn on supply power, release power-down and enable the reference clock;
- open the clock gates (reference, lane, bus) one per cycle;
- wait for the clocks to settle;
- wait for the controller configuration to finish;
- re-enable training and sample link-up at coarse intervals.

The block generates no clocks, holds no PHY parameter values and does no link training itself.

Every delay is a cycle count derived from a clock-frequency parameter. A fast-simulation parameter replaces the counts with short fixed values:

| Delay | Normal | Fast mode |
|---|---|---|
| Endpoint reset hold | 100 ms | 20 cycles |
| Clock settle | 150 µs | 8 cycles |
| Link-up poll interval | 100 ms | 16 cycles |

After ten failed link-up samples the block reports a timeout.

Top module: `link_bringup_seq`

## Requirements
- R1: Out of reset, the outputs are in the safe state: test power-down 1, endpoint reset line 0, and reference clock, training enable, power enable, all clock gates, busy, done and fail all 0.
- R2: A start request accepted from idle, done or fail enters the assert phase. In that phase busy=1, test power-down=1, training enable=1, reference clock=0 and endpoint reset=0. The phase lasts the reset hold (20 cycles in fast mode). In the same cycle that ends it, the endpoint reset rises to 1 and training enable falls to 0.
- R3: After the reset release, these steps follow one clock apart, in this order:
  - power enable set;
  - test power-down cleared;
  - reference clock enabled;
  - gate bit 0 (reference) set;
  - gate bit 1 (lane) set;
  - gate bit 2 (bus) set.
- R4: The clock settle period (8 cycles in fast mode) starts one cycle after the bus gate opens. With configuration-done already high, training enable rises 10 cycles after the bus gate opens.
- R5: While configuration-done is low, training enable stays 0 after the settle period. It rises only after configuration-done goes high.
- R6: Link-up is sampled once per poll interval (16 cycles in fast mode), counted from the rise of training enable. On the first sample that sees link-up high, done=1 and busy=0, and all drive outputs keep their values.
- R7: After 10 consecutive samples with link-up low, fail=1 and busy=0. This happens 160 cycles after training enable rises in fast mode.
- R8: A start request while busy=1 has no effect; the running sequence keeps its timing.
- R9: A start request from done or fail restarts the assert phase. It clears power enable, the reference clock, all gates, done and fail in that cycle.
- R10: Asserting rst_ni mid-sequence puts all outputs in the safe state of R1 at once, without waiting for a clock edge.
- R11: Link-up is only looked at on sample cycles. A pulse of link-up that ends between two samples does not finish the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled each cycle |
| cfg_done_i | input | 1 | Controller configuration complete |
| link_up_i | input | 1 | Link-up status from the controller |
| phy_test_pd_o | output | 1 | PHY test power-down |
| refclk_en_o | output | 1 | Reference clock enable |
| train_en_o | output | 1 | Link-training enable |
| ep_rst_no | output | 1 | Endpoint reset, active low |
| pwr_en_o | output | 1 | Slot power enable |
| clk_gate_en_o | output | NUM_GATES | Clock gate enables: bit 0 reference, bit 1 lane, bit 2 bus |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Link came up |
| fail_o | output | 1 | Link-up timeout |

## Verification
The hardest case to reach from the ports is a link-up level that matters only at coarse sample instants. To cover it, the stimulus waits for the rise of training enable, then counts cycles from it. It places a short link-up pulse between two samples and raises link-up for good only after two samples have failed. The done flag must then appear exactly three intervals after training rises.

The configuration-done gate is covered by holding that input low well past the settle period before releasing it. Ignored start requests are covered by pulsing start in the middle of the run; the scoreboard's per-step cycle distances then catch any restart.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ASSERT, ST_PHYCFG, ST_PWR, ST_PDCLR, ST_REFCLK,
    ST_GATE, ST_SETTLE, ST_WAITCFG, ST_POLL, ST_DONE, ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/lbs_delay_timer.sv
module lbs_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R2: a loaded delay starts from the requested count
  assert_tmr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
endmodule

// File: rtl/lbs_poll_ctr.sv
module lbs_poll_ctr #(
  parameter int MAX = 10,
  parameter int W   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == W'(MAX - 1));

  assert_cnt_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(MAX));
  assert_no_inc_at_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter bit FAST_SIM  = 1'b0,
  parameter int MAX_POLLS = 10,
  parameter int NUM_GATES = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 cfg_done_i,
  input  logic                 link_up_i,
  output logic                 phy_test_pd_o,
  output logic                 refclk_en_o,
  output logic                 train_en_o,
  output logic                 ep_rst_no,
  output logic                 pwr_en_o,
  output logic [NUM_GATES-1:0] clk_gate_en_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fail_o
);
  localparam int RST_CYC    = FAST_SIM ? 20 : CLK_HZ / 10;
  localparam int SETTLE_CYC = FAST_SIM ? 8  : (CLK_HZ / 1_000_000) * 150;
  localparam int POLL_CYC   = FAST_SIM ? 16 : CLK_HZ / 10;
  localparam int MAX_A      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAX_DLY    = (MAX_A > POLL_CYC) ? MAX_A : POLL_CYC;
  localparam int TMR_W      = $clog2(MAX_DLY + 1);
  localparam int CNT_W      = $clog2(MAX_POLLS + 1);

  seq_state_e           state_q;
  logic                 pd_q, refclk_q, train_q, eprst_nq, pwr_q, done_q, fail_q;
  logic [NUM_GATES-1:0] gate_q;

  logic             tmr_load, tmr_exp, poll_last;
  logic [TMR_W-1:0] tmr_val;
  logic             idle_like, start_ok, poll_clr, poll_inc, poll_sample, settle_go;

  assign idle_like   = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign start_ok    = idle_like && start_i;
  assign settle_go   = (state_q == ST_GATE) && gate_q[NUM_GATES-1];
  assign poll_clr    = (state_q == ST_WAITCFG) && cfg_done_i;
  assign poll_sample = (state_q == ST_POLL) && tmr_exp;
  assign poll_inc    = poll_sample && !link_up_i && !poll_last;

  always_comb begin
    tmr_load = start_ok || settle_go || poll_clr || poll_inc;
    if (start_ok)       tmr_val = TMR_W'(RST_CYC - 1);
    else if (settle_go) tmr_val = TMR_W'(SETTLE_CYC - 1);
    else                tmr_val = TMR_W'(POLL_CYC - 1);
  end

  lbs_delay_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .expired_o(tmr_exp)
  );

  lbs_poll_ctr #(.MAX(MAX_POLLS), .W(CNT_W)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc), .last_o(poll_last)
  );

  // Each state's output change is applied on the edge that enters it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pd_q     <= 1'b1;
      refclk_q <= 1'b0;
      train_q  <= 1'b0;
      eprst_nq <= 1'b0;
      pwr_q    <= 1'b0;
      gate_q   <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: if (start_i) begin
          state_q  <= ST_ASSERT;
          pd_q     <= 1'b1;
          refclk_q <= 1'b0;
          train_q  <= 1'b1;
          eprst_nq <= 1'b0;
          pwr_q    <= 1'b0;
          gate_q   <= '0;
          done_q   <= 1'b0;
          fail_q   <= 1'b0;
        end
        ST_ASSERT: if (tmr_exp) begin
          state_q  <= ST_PHYCFG;
          eprst_nq <= 1'b1;
          train_q  <= 1'b0;
        end
        ST_PHYCFG: begin state_q <= ST_PWR;    pwr_q    <= 1'b1; end
        ST_PWR:    begin state_q <= ST_PDCLR;  pd_q     <= 1'b0; end
        ST_PDCLR:  begin state_q <= ST_REFCLK; refclk_q <= 1'b1; end
        ST_REFCLK: begin
          state_q <= ST_GATE;
          gate_q  <= {{(NUM_GATES-1){1'b0}}, 1'b1};
        end
        ST_GATE: begin
          if (gate_q[NUM_GATES-1]) state_q <= ST_SETTLE;
          else                     gate_q  <= {gate_q[NUM_GATES-2:0], 1'b1};
        end
        ST_SETTLE:  if (tmr_exp) state_q <= ST_WAITCFG;
        ST_WAITCFG: if (cfg_done_i) begin
          state_q <= ST_POLL;
          train_q <= 1'b1;
        end
        ST_POLL: if (tmr_exp) begin
          if (link_up_i) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else if (poll_last) begin
            state_q <= ST_FAIL;
            fail_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign phy_test_pd_o = pd_q;
  assign refclk_en_o   = refclk_q;
  assign train_en_o    = train_q;
  assign ep_rst_no     = eprst_nq;
  assign pwr_en_o      = pwr_q;
  assign clk_gate_en_o = gate_q;
  assign busy_o        = !idle_like;
  assign done_o        = done_q;
  assign fail_o        = fail_q;

  for (genvar g = 1; g < NUM_GATES; g++) begin : g_gate_chk
    assert_gate_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_q[g] |-> gate_q[g-1]);
  end

  assert_gate_after_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q[0] |-> (refclk_q && !pd_q && pwr_q));
  assert_train_needs_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(train_q) && pwr_q) |-> $past(cfg_done_i));
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_ASSERT) |=> state_q != ST_ASSERT);
  assert_result_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && fail_q));
endmodule

// File: tb/link_bringup_seq_bench.sv
module link_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, cfg_done = 1'b0, link_up = 1'b0;
  logic pd, refclk, train, ep_rst_n, pwr, busy, done, fail;
  logic [2:0] gates;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq #(.FAST_SIM(1'b1)) u_link_bringup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .cfg_done_i(cfg_done),
    .link_up_i(link_up), .phy_test_pd_o(pd), .refclk_en_o(refclk),
    .train_en_o(train), .ep_rst_no(ep_rst_n), .pwr_en_o(pwr),
    .clk_gate_en_o(gates), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  // {busy,done,fail,pd,refclk,train,ep_rst_n,pwr,gates}
  function automatic logic [10:0] mk(logic b, logic d, logic f, logic p, logic r,
                                     logic t, logic e, logic w, logic [2:0] g);
    return {b, d, f, p, r, t, e, w, g};
  endfunction

  wire [10:0] snap = {busy, done, fail, pd, refclk, train, ep_rst_n, pwr, gates};
  localparam logic [10:0] SAFE = 11'b000_1_0_0_0_0_000;

  logic [10:0] exp_val[$];
  int          exp_dly[$];
  string       exp_tag[$];
  logic        mon_en = 1'b0;
  logic [10:0] prev;
  int          cyc;

  task automatic push(int dly, logic [10:0] v, string tag);
    exp_val.push_back(v); exp_dly.push_back(dly); exp_tag.push_back(tag);
  endtask

  task automatic chk(bit ok, string tag, logic [10:0] act, logic [10:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%b exp=%b", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per output change
  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (snap !== prev) begin
        if (exp_val.size() == 0) begin
          checks++; failures++;
          $display("FAIL R8 unexpected change: act=%b exp=%b", snap, prev);
        end else begin
          logic [10:0] v; int d; string t;
          v = exp_val.pop_front(); d = exp_dly.pop_front(); t = exp_tag.pop_front();
          chk(snap === v, t, snap, v);
          if (d >= 0) begin
            checks++;
            if (cyc != d) begin
              failures++;
              $display("FAIL %s delay: act=%0d exp=%0d", t, cyc, d);
            end
          end
        end
        cyc = 0;
        prev = snap;
      end
    end
  end

  task automatic mon_arm();
    @(negedge clk);
    prev = snap; cyc = 0; mon_en = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_drain(int limit);
    for (int i = 0; i < limit && exp_val.size() != 0; i++) begin
      @(negedge clk); #1;
    end
    checks++;
    if (exp_val.size() != 0) begin
      failures++;
      $display("FAIL %s: act=pending exp=drained", exp_tag[0]);
      exp_val.delete(); exp_dly.delete(); exp_tag.delete();
    end
  endtask

  // expected steps through the bus gate
  task automatic push_front_half();
    push(-1, mk(1,0,0,1,0,1,0,0,3'b000), "R2/R9 assert phase");
    push(20, mk(1,0,0,1,0,0,1,0,3'b000), "R2 reset release");
    push(1,  mk(1,0,0,1,0,0,1,1,3'b000), "R3 power");
    push(1,  mk(1,0,0,0,0,0,1,1,3'b000), "R3 pd clear");
    push(1,  mk(1,0,0,0,1,0,1,1,3'b000), "R3 refclk");
    push(1,  mk(1,0,0,0,1,0,1,1,3'b001), "R3 gate ref");
    push(1,  mk(1,0,0,0,1,0,1,1,3'b011), "R3 gate lane");
    push(1,  mk(1,0,0,0,1,0,1,1,3'b111), "R3 gate bus");
  endtask

  localparam logic [10:0] TRAIN_ON = 11'b100_0_1_1_1_1_111;
  localparam logic [10:0] DONE_V   = 11'b010_0_1_1_1_1_111;
  localparam logic [10:0] FAIL_V   = 11'b001_0_1_1_1_1_111;

  initial begin
    repeat (100_000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(snap === SAFE, "R1 reset state", snap, SAFE);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(snap === SAFE, "R1 idle after reset", snap, SAFE);

    // normal run, with ignored start requests (R8)
    cfg_done = 1'b1; link_up = 1'b1;
    mon_arm();
    push_front_half();
    push(10, TRAIN_ON, "R4 train after settle");
    push(16, DONE_V, "R6 done on first sample");
    pulse_start();
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R8
    @(posedge train);
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R8 during poll
    wait_drain(200);

    // restart from done; link pulse between samples (R11), up at third sample
    link_up = 1'b0;
    push_front_half();
    push(10, TRAIN_ON, "R4 train");
    push(48, DONE_V, "R11 done at third sample");
    pulse_start();
    @(posedge train);
    @(negedge clk);
    repeat (4) @(negedge clk); link_up = 1'b1;
    repeat (2) @(negedge clk); link_up = 1'b0;
    repeat (34) @(negedge clk); link_up = 1'b1;
    wait_drain(200);

    // configuration-done gating (R5)
    cfg_done = 1'b0;
    push_front_half();
    pulse_start();
    wait_drain(200);
    repeat (30) @(negedge clk);
    chk(train === 1'b0, "R5 train held without cfg", {10'b0, train}, 11'b0);
    push(-1, TRAIN_ON, "R5 train after cfg");
    push(16, DONE_V, "R6 done");
    cfg_done = 1'b1;
    wait_drain(200);

    // timeout (R7), then restart from fail (R9)
    link_up = 1'b0;
    push_front_half();
    push(10, TRAIN_ON, "R4 train");
    push(160, FAIL_V, "R7 timeout");
    pulse_start();
    wait_drain(400);
    link_up = 1'b1;
    push_front_half();
    push(10, TRAIN_ON, "R4 train");
    push(16, DONE_V, "R9 done after restart");
    pulse_start();
    wait_drain(200);

    // asynchronous reset mid-sequence (R10)
    mon_en = 1'b0;
    pulse_start();
    repeat (25) @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 chk(snap === SAFE, "R10 async safe", snap, SAFE);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(snap === SAFE, "R10 idle after reset", snap, SAFE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule